// File: doc/BRIEF.md
# USB Device Global Control Register

This block is the byte-wide global control register of a USB device controller, together with the small line-state monitors its bits depend on. Software writes the register to enable the controller, to stop its 48 MHz clock during suspend, to mark the device configured or addressed, and to request a remote wakeup. Hardware watches the bus line state on every bit-time tick. It recognises a bus reset from a sustained SE0, tracks how long the bus has been idle, and drives the upstream resume K state when a wakeup request is allowed.

The control outputs go to the rest of the controller. These are a soft reset, a transceiver enable, a 48 MHz clock enable, a one-cycle bus-reset pulse, a suspended flag, a resume-drive request and the function address presented to the packet engine. All time limits are counted in bit-time ticks. The `TICKS_PER_MS` parameter sets how many ticks make one millisecond.

Top module: `usb_gctl`

## Requirements
- R1: After reset the register reads 0x00, `ctl_reset` is 1, and `xcvr_en`, `clk48_en`, `bus_reset`, `bus_suspended` and `resume_k` are 0.
- R2: Register layout: bit 7 enable, bit 6 clock stop, bit 5 wakeup request, bit 4 reserved, bit 3 resume-in-progress status, bit 2 wakeup permission, bit 1 configured, bit 0 address valid. A write (`reg_wr`=1 at a clock edge) loads bits 7, 6, 5, 2, 1 and 0 from `reg_wdata`. Writes to bit 4 and bit 3 are ignored, and bit 4 always reads 0.
- R3: `ctl_reset` is the inverse and `xcvr_en` the copy of the enable bit. While the enable bit is 0, no bus reset is detected and no suspend time accumulates. Clearing the enable bit during a resume ends the drive one cycle later, and the wakeup request bit keeps its value.
- R4: `clk48_en` is 1 exactly when the enable bit is 1 and the clock-stop bit is 0. Idle-time tracking continues while the clock is stopped.
- R5: `line_state` encodes 00 SE0, 01 J (idle), 10 K, 11 SE1. On the tick that completes 32 consecutive SE0 ticks, `bus_reset` pulses high for one cycle, in the cycle after that edge. A longer SE0 produces no second pulse, and any non-SE0 state restarts the count.
- R6: The edge after a `bus_reset` pulse clears the configured and address-valid bits, and leaves the other bits unchanged. This clear wins over a software write on that edge.
- R7: `bus_suspended` rises after 3 ms of consecutive J ticks, and falls one cycle after any non-J line state.
- R8: A resume starts only when the wakeup request, wakeup permission and enable bits are 1, the clock-stop bit is 0, and the bus has been idle for at least 8 ms (3 ms to enter suspend plus 5 ms in suspend). `resume_k` and status bit 3 rise two edges after the write that completes these conditions. If the conditions are met later, they rise one edge after that.
- R9: The drive lasts `wake_ms` milliseconds of ticks, where a `wake_ms` of 0 counts as 1. On the edge that ends it, status bit 3, `resume_k` and the wakeup request bit all clear together.
- R10: `func_addr_out` equals `func_addr_in` while the address-valid bit is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| bit_tick | input | 1 | One pulse per full-speed bit time |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| wake_ms | input | 4 | Resume drive length in ms (0 means 1) |
| func_addr_in | input | 7 | Function address assigned by firmware |
| func_addr_out | output | 7 | Function address given to the packet engine |
| clk48_en | output | 1 | 48 MHz clock gate enable |
| xcvr_en | output | 1 | Transceiver enable |
| ctl_reset | output | 1 | Controller soft reset, active high |
| bus_reset | output | 1 | One-cycle bus reset detected pulse |
| bus_suspended | output | 1 | Bus idle for at least 3 ms |
| resume_k | output | 1 | Drive K state for upstream resume |

## Verification
Register fields and the static outputs derived from them are due one edge after the write edge. The bench reads them at the next falling edge. A bus reset pulse is due after the 32nd SE0 edge and its flag clear one edge later. `bus_suspended` is due after the 3 ms-th J edge. The bench steps exactly those edge counts, checks one edge early for the old value and then checks the new value. A resume is due two edges after the enabling write, or one edge after the 8 ms-th idle edge. Its end is due `wake_ms` milliseconds of ticks after it starts. Each of these is checked on both sides of the expected edge.

// File: rtl/usb_gctl_pkg.sv
package usb_gctl_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    // register bit positions
    localparam int B_EN   = 7;
    localparam int B_CSTP = 6;
    localparam int B_WREQ = 5;
    localparam int B_RSV  = 4;
    localparam int B_RIP  = 3;
    localparam int B_WPRM = 2;
    localparam int B_CFG  = 1;
    localparam int B_AVAL = 0;

    typedef struct packed {
        logic en;
        logic cstp;
        logic wreq;
        logic wprm;
        logic cfg;
        logic aval;
    } ctl_t;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_DRIVE = 1'b1
    } wstate_t;

endpackage

// File: rtl/usb_gctl_se0det.sv
module usb_gctl_se0det #(
    parameter int RST_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic se0,
    output logic rst_pulse
);
    localparam int CW = $clog2(RST_BITS + 1);
    localparam logic [CW-1:0] LIM  = CW'(RST_BITS);
    localparam logic [CW-1:0] LAST = CW'(RST_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!run || !se0) begin
            st_d.cnt = '0;
        end else if (tick && st_q.cnt != LIM) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_pulse = st_q.pulse;
endmodule

// File: rtl/usb_gctl_idletmr.sv
module usb_gctl_idletmr #(
    parameter int TICKS_PER_MS = 12000,
    parameter int SUSP_MS      = 3,
    parameter int WAKE_MS      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic idle_j,
    output logic suspended,
    output logic wake_ok
);
    localparam int SUSP_TICKS = SUSP_MS * TICKS_PER_MS;
    localparam int OK_TICKS   = (SUSP_MS + WAKE_MS) * TICKS_PER_MS;
    localparam int CW         = $clog2(OK_TICKS + 1);
    localparam logic [CW-1:0] SUSP_C = CW'(SUSP_TICKS);
    localparam logic [CW-1:0] OK_C   = CW'(OK_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || !idle_j) begin
            st_d.cnt = '0;
        end else if (tick && st_q.cnt != OK_C) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign suspended = (st_q.cnt >= SUSP_C);
    assign wake_ok   = (st_q.cnt == OK_C);
endmodule

// File: rtl/usb_gctl_wakeseq.sv
module usb_gctl_wakeseq
    import usb_gctl_pkg::*;
#(
    parameter int TICKS_PER_MS = 12000,
    parameter int DUR_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             req,
    input  logic             wake_ok,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur_ms,
    output logic             driving,
    output logic             done
);
    localparam int DRV_MAX = ((1 << DUR_W) - 1) * TICKS_PER_MS;
    localparam int DW      = $clog2(DRV_MAX + 1);

    typedef struct packed {
        wstate_t       st;
        logic [DW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DUR_W-1:0] dur_eff;
    logic [DW-1:0]    target;
    logic             last;

    always_comb begin
        dur_eff = (dur_ms == '0) ? DUR_W'(1) : dur_ms;
        target  = DW'(dur_eff) * DW'(TICKS_PER_MS);
        last    = (st_q.st == WS_DRIVE) && tick && (st_q.cnt == target - 1'b1);
    end

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.st  = WS_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.st)
                WS_IDLE: begin
                    st_d.cnt = '0;
                    if (req && wake_ok) begin
                        st_d.st = WS_DRIVE;
                    end
                end
                WS_DRIVE: begin
                    if (last) begin
                        st_d.st  = WS_IDLE;
                        st_d.cnt = '0;
                    end else if (tick) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.st = WS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: WS_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign driving = (st_q.st == WS_DRIVE);
    assign done    = run && last;
endmodule

// File: rtl/usb_gctl.sv
module usb_gctl
    import usb_gctl_pkg::*;
#(
    parameter int TICKS_PER_MS = 12000,
    parameter int RST_BITS     = 32,
    parameter int SUSP_MS      = 3,
    parameter int WAKE_MS      = 5,
    parameter int DUR_W        = 4,
    parameter int ADDR_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bit_tick,
    input  logic [1:0]        line_state,
    input  logic [DUR_W-1:0]  wake_ms,
    input  logic [ADDR_W-1:0] func_addr_in,
    output logic [ADDR_W-1:0] func_addr_out,
    output logic              clk48_en,
    output logic              xcvr_en,
    output logic              ctl_reset,
    output logic              bus_reset,
    output logic              bus_suspended,
    output logic              resume_k
);
    ctl_t ctl_d, ctl_q;
    logic se0, idle_j, wake_ok, driving, done, clocks_on;

    assign se0       = (line_state == LS_SE0);
    assign idle_j    = (line_state == LS_J);
    assign clocks_on = ctl_q.en && !ctl_q.cstp;

    usb_gctl_se0det #(.RST_BITS(RST_BITS)) u_se0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_q.en),
        .tick      (bit_tick),
        .se0       (se0),
        .rst_pulse (bus_reset)
    );

    usb_gctl_idletmr #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .SUSP_MS      (SUSP_MS),
        .WAKE_MS      (WAKE_MS)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_q.en),
        .tick      (bit_tick),
        .idle_j    (idle_j),
        .suspended (bus_suspended),
        .wake_ok   (wake_ok)
    );

    usb_gctl_wakeseq #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .DUR_W        (DUR_W)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.en),
        .req     (ctl_q.wreq && ctl_q.wprm && clocks_on),
        .wake_ok (wake_ok),
        .tick    (bit_tick),
        .dur_ms  (wake_ms),
        .driving (driving),
        .done    (done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) begin
            ctl_d.en   = reg_wdata[B_EN];
            ctl_d.cstp = reg_wdata[B_CSTP];
            ctl_d.wreq = reg_wdata[B_WREQ];
            ctl_d.wprm = reg_wdata[B_WPRM];
            ctl_d.cfg  = reg_wdata[B_CFG];
            ctl_d.aval = reg_wdata[B_AVAL];
        end
        if (bus_reset) begin
            ctl_d.cfg  = 1'b0;
            ctl_d.aval = 1'b0;
        end
        if (done) begin
            ctl_d.wreq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_EN]   = ctl_q.en;
        reg_rdata[B_CSTP] = ctl_q.cstp;
        reg_rdata[B_WREQ] = ctl_q.wreq;
        reg_rdata[B_RSV]  = 1'b0;
        reg_rdata[B_RIP]  = driving;
        reg_rdata[B_WPRM] = ctl_q.wprm;
        reg_rdata[B_CFG]  = ctl_q.cfg;
        reg_rdata[B_AVAL] = ctl_q.aval;
    end

    assign clk48_en      = clocks_on;
    assign xcvr_en       = ctl_q.en;
    assign ctl_reset     = !ctl_q.en;
    assign resume_k      = driving;
    assign func_addr_out = ctl_q.aval ? func_addr_in : '0;
endmodule

// File: rtl/usb_gctl_chk.sv
module usb_gctl_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_rdata,
    input logic [1:0]        line_state,
    input logic [ADDR_W-1:0] func_addr_out,
    input logic              clk48_en,
    input logic              xcvr_en,
    input logic              ctl_reset,
    input logic              bus_reset,
    input logic              bus_suspended,
    input logic              resume_k
);
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] == 1'b0);

    a_r4_off_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[7] |-> (!clk48_en && ctl_reset && !xcvr_en));

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);

    a_r5_from_se0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> $past(line_state == 2'b00));

    a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (reg_rdata[1:0] == 2'b00));

    a_r7_non_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state != 2'b01) |=> !bus_suspended);

    a_r8_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_k) |-> $past(reg_rdata[5] && reg_rdata[2] && clk48_en && bus_suspended));

    a_r9_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(resume_k) && $past(reg_rdata[7])) |-> !reg_rdata[5]);

    a_r10_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> (func_addr_out == '0));
endmodule

bind usb_gctl usb_gctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rdata     (reg_rdata),
    .line_state    (line_state),
    .func_addr_out (func_addr_out),
    .clk48_en      (clk48_en),
    .xcvr_en       (xcvr_en),
    .ctl_reset     (ctl_reset),
    .bus_reset     (bus_reset),
    .bus_suspended (bus_suspended),
    .resume_k      (resume_k)
);

// File: tb/usb_gctl_test.sv
module usb_gctl_test;
    localparam int TPM = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bit_tick = 1'b1;
    logic [1:0] line_state = 2'b10;
    logic [3:0] wake_ms = 4'd2;
    logic [6:0] func_addr_in = '0;
    logic [6:0] func_addr_out;
    logic       clk48_en, xcvr_en, ctl_reset, bus_reset, bus_suspended, resume_k;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usb_gctl #(.TICKS_PER_MS(TPM)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bit_tick(bit_tick), .line_state(line_state),
        .wake_ms(wake_ms), .func_addr_in(func_addr_in), .func_addr_out(func_addr_out),
        .clk48_en(clk48_en), .xcvr_en(xcvr_en), .ctl_reset(ctl_reset),
        .bus_reset(bus_reset), .bus_suspended(bus_suspended), .resume_k(resume_k)
    );

    function automatic logic [7:0] exp_rd(logic [7:0] w);
        return w & 8'hE7;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 ctl_reset", ctl_reset, 1);
        check("R1 outs", {xcvr_en, clk48_en, bus_reset, bus_suspended, resume_k}, 0);

        // R2 R4 R10 random writes, line held at K
        for (int i = 0; i < 40; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            func_addr_in = 7'($urandom);
            wr(v);
            check("R2 readback", reg_rdata, exp_rd(v));
            check("R3 ctl_reset/xcvr_en", {ctl_reset, xcvr_en}, {~v[7], v[7]});
            check("R4 clk48_en", clk48_en, v[7] & ~v[6]);
            check("R10 addr", func_addr_out, v[0] ? func_addr_in : 7'd0);
        end
        wr(8'h18);
        check("R2 bits 4,3 ignored", reg_rdata, 8'h00);

        // R5 R6 bus reset detection
        wr(8'h83);
        line_state = 2'b00;
        step(31);
        check("R5 no pulse at 31", bus_reset, 0);
        step(1);
        check("R5 pulse at 32", bus_reset, 1);
        check("R6 flags before clear", reg_rdata, 8'h83);
        step(1);
        check("R5 pulse one cycle", bus_reset, 0);
        check("R6 flags cleared", reg_rdata, 8'h80);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                step(1);
                seen += bus_reset;
            end
            check("R5 saturate no repulse", seen, 0);
        end
        line_state = 2'b10;
        step(1);
        // write on the pulse edge
        wr(8'h83);
        line_state = 2'b00;
        step(32);
        check("R5 pulse before collide", bus_reset, 1);
        wr(8'h83);
        check("R6 reset wins over write", reg_rdata, 8'h80);
        line_state = 2'b10;
        step(1);
        // interrupted SE0 restarts count
        wr(8'h83);
        line_state = 2'b00;
        step(20);
        line_state = 2'b01;
        step(1);
        line_state = 2'b00;
        step(31);
        check("R5 restart no pulse", bus_reset, 0);
        check("R5 restart flags kept", reg_rdata, 8'h83);
        step(1);
        check("R5 restart pulse", bus_reset, 1);
        line_state = 2'b10;
        step(2);
        // disabled: no detection
        wr(8'h03);
        line_state = 2'b00;
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                step(1);
                seen += bus_reset;
            end
            check("R3 no bus reset when off", seen, 0);
        end
        check("R3 flags kept when off", reg_rdata, 8'h03);
        line_state = 2'b10;
        step(1);

        // R7 suspend
        wr(8'h80);
        line_state = 2'b01;
        step(3 * TPM - 1);
        check("R7 not yet suspended", bus_suspended, 0);
        step(1);
        check("R7 suspended", bus_suspended, 1);
        line_state = 2'b10;
        step(1);
        check("R7 non-idle drops", bus_suspended, 0);
        wr(8'hC0);
        line_state = 2'b01;
        step(3 * TPM);
        check("R4 suspend tracked with clock stopped", {bus_suspended, clk48_en}, 2'b10);
        line_state = 2'b10;
        step(1);

        // R8 R9 resume
        wr(8'h84);
        line_state = 2'b01;
        step(8 * TPM);
        wake_ms = 4'd2;
        wr(8'hA4);
        check("R8 not yet driving", {resume_k, reg_rdata}, {1'b0, 8'hA4});
        step(1);
        check("R8 drive start", {resume_k, reg_rdata}, {1'b1, 8'hAC});
        step(2 * TPM - 1);
        check("R9 still driving", resume_k, 1);
        step(1);
        check("R9 drive end", {resume_k, reg_rdata}, {1'b0, 8'h84});
        // clock stopped blocks
        wr(8'hE4);
        step(10);
        check("R8 clock stop blocks", {resume_k, reg_rdata}, {1'b0, 8'hE4});
        wake_ms = 4'd0;
        wr(8'hA4);
        step(1);
        check("R8 start after clock on", resume_k, 1);
        step(TPM - 1);
        check("R9 zero length still 1ms", resume_k, 1);
        step(1);
        check("R9 zero length end", {resume_k, reg_rdata}, {1'b0, 8'h84});
        // permission off blocks
        wr(8'hA0);
        step(15);
        check("R8 permission blocks", {resume_k, reg_rdata}, {1'b0, 8'hA0});
        wr(8'h80);
        // pending request waits for idle time
        line_state = 2'b10;
        wake_ms = 4'd1;
        wr(8'hA4);
        line_state = 2'b01;
        step(8 * TPM);
        check("R8 waits full idle", resume_k, 0);
        step(1);
        check("R8 starts at idle limit", resume_k, 1);
        // abort by disabling
        wr(8'h24);
        step(1);
        check("R3 abort drive", {resume_k, ctl_reset, reg_rdata}, {1'b0, 1'b1, 8'h24});
        line_state = 2'b10;
        step(2);

        finish_run();
    end
endmodule